// File: doc/BRIEF.md
# Locked Configuration Store Access Controller

This block arbitrates every access to a device configuration store: a fuse array held in block RAM, a separate bank of eight signature bytes, and a lock bit that can only be set. A single command port with a ready/valid handshake carries seven operations. These are fuse read, fuse write, signature read, signature write, register preload, lock set and full erase. Each command ends with a one-cycle done pulse that carries the read data and an error flag.

Once the lock is set, fuse readback and preload are refused from the next command on. A refused command answers at once with zero data and the error flag, and it does not stall. The signature bank stays readable and writable whether or not the lock is set. The only way to clear the lock is the erase command. Erase walks the whole fuse array one word per cycle, writes the erased value (all ones) to every word, and then clears the lock.

Top module: `cfg_guard_ctrl`

## Requirements
- R1: Reset drives cmd_ready_o high, rsp_done_o and preload_stb_o low, and clears the lock (locked_o low).
- R2: A command is taken on a clock edge where cmd_valid_i and cmd_ready_o are both high. cmd_ready_o is low in the following cycle. rsp_done_o is a single-cycle pulse per command.
- R3: When unlocked, fuse write (op 1) stores cmd_wdata_i at cmd_addr_i, and fuse read (op 0) returns the stored word with the error flag low.
- R4: Signature write (op 3) stores cmd_wdata_i[7:0] in the byte selected by cmd_addr_i[2:0]. Signature read (op 2) returns that byte with the error flag low.
- R5: Lock set (op 5) raises locked_o. While locked, a fuse read answers with rsp_data_o all zeros and rsp_err_o high.
- R6: Preload (op 4) while unlocked pulses preload_stb_o with preload_val_o equal to cmd_wdata_i, in the same cycle as the done pulse. While locked, preload_stb_o stays low and rsp_err_o is high.
- R7: Signature reads and writes work the same whether locked or unlocked.
- R8: A lock set applies to the very next command accepted after it.
- R9: Erase (op 6) writes all ones to every fuse word and clears the lock. Its done pulse follows after the array sweep, within DEPTH+3 cycles. It leaves the signature bytes unchanged.
- R10: The reserved op 7 answers with rsp_err_o high and changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 3 | Operation code (0..7, see requirements) |
| cmd_addr_i | input | ADDR_W | Fuse word address; bits [2:0] select the signature byte |
| cmd_wdata_i | input | DATA_W | Write or preload data |
| cmd_ready_o | output | 1 | Controller idle, will accept a command |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Command refused or undefined, valid with done |
| rsp_data_o | output | DATA_W | Read result, valid with done |
| preload_stb_o | output | 1 | Preload strobe to the target registers |
| preload_val_o | output | DATA_W | Value to preload |
| locked_o | output | 1 | Lock bit state |

## Verification
The hardest state to reach from the ports is the locked state with known fuse contents, followed by proof that erase really reopens readback. The stimulus first erases and writes known words. It sets the lock, reads the same addresses to get refused answers, and erases again. It then reads the addresses back as all ones, while the signature bytes written before the lock survive. A reserved opcode is placed between a write and its readback to show that it changes nothing.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [2:0] {
    OP_RD_FUSE = 3'd0,
    OP_WR_FUSE = 3'd1,
    OP_RD_SIG  = 3'd2,
    OP_WR_SIG  = 3'd3,
    OP_PRELOAD = 3'd4,
    OP_LOCK    = 3'd5,
    OP_ERASE   = 3'd6,
    OP_RSVD    = 3'd7
  } cg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXEC  = 2'd1,
    ST_SWEEP = 2'd2
  } cg_state_e;

  localparam int SIG_BYTES = 8;
  localparam int SIG_IDX_W = 3;
endpackage

// File: rtl/cfg_fuse_mem.sv
module cfg_fuse_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) cells[waddr_i] <= wdata_i;
    rdata_o <= cells[raddr_i];
  end
endmodule

// File: rtl/cfg_sig_bank.sv
module cfg_sig_bank
  import cfg_guard_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 we_i,
  input  logic [SIG_IDX_W-1:0] idx_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o
);
  logic [7:0] bytes_q [SIG_BYTES];

  for (genvar g = 0; g < SIG_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i) begin
      if (rst_i)
        bytes_q[g] <= 8'h00;
      else if (we_i && (idx_i == SIG_IDX_W'(g)))
        bytes_q[g] <= wdata_i;
    end
  end

  assign rdata_o = bytes_q[idx_i];
endmodule

// File: rtl/cfg_lock_bit.sv
module cfg_lock_bit (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic lock_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)      lock_o <= 1'b0;
    else if (clr_i) lock_o <= 1'b0;
    else if (set_i) lock_o <= 1'b1;
  end
endmodule

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
  import cfg_guard_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              cmd_ready_o,
  output logic              rsp_done_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              preload_stb_o,
  output logic [DATA_W-1:0] preload_val_o,
  output logic              locked_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [DATA_W-1:0] ERASED    = {DATA_W{1'b1}};

  cg_state_e         st_q;
  cg_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] sweep_q;
  logic              lock_q;
  logic              accept;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              sig_we;
  logic [7:0]        sig_rdata;
  logic              lock_set;
  logic              lock_clr;

  assign accept      = cmd_valid_i && (st_q == ST_IDLE);
  assign cmd_ready_o = (st_q == ST_IDLE);
  assign locked_o    = lock_q;

  assign mem_we    = (st_q == ST_SWEEP) || ((st_q == ST_EXEC) && (op_q == OP_WR_FUSE));
  assign mem_waddr = (st_q == ST_SWEEP) ? sweep_q : addr_q;
  assign mem_wdata = (st_q == ST_SWEEP) ? ERASED : wdata_q;
  assign sig_we    = (st_q == ST_EXEC) && (op_q == OP_WR_SIG);
  assign lock_set  = (st_q == ST_EXEC) && (op_q == OP_LOCK);
  assign lock_clr  = (st_q == ST_SWEEP) && (sweep_q == LAST_ADDR);

  cfg_fuse_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fuse_i (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (cmd_addr_i),
    .rdata_o (mem_rdata)
  );

  cfg_sig_bank sig_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (sig_we),
    .idx_i   (addr_q[SIG_IDX_W-1:0]),
    .wdata_i (wdata_q[7:0]),
    .rdata_o (sig_rdata)
  );

  cfg_lock_bit lock_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .set_i  (lock_set),
    .clr_i  (lock_clr),
    .lock_o (lock_q)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q          <= ST_IDLE;
      op_q          <= OP_RSVD;
      addr_q        <= '0;
      wdata_q       <= '0;
      sweep_q       <= '0;
      rsp_done_o    <= 1'b0;
      rsp_err_o     <= 1'b0;
      rsp_data_o    <= '0;
      preload_stb_o <= 1'b0;
      preload_val_o <= '0;
    end else begin
      rsp_done_o    <= 1'b0;
      preload_stb_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= cg_op_e'(cmd_op_i);
            addr_q  <= cmd_addr_i;
            wdata_q <= cmd_wdata_i;
            st_q    <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          st_q       <= ST_IDLE;
          rsp_done_o <= 1'b1;
          rsp_err_o  <= 1'b0;
          rsp_data_o <= '0;
          unique case (op_q)
            OP_RD_FUSE: begin
              if (lock_q) rsp_err_o  <= 1'b1;
              else        rsp_data_o <= mem_rdata;
            end
            OP_RD_SIG: rsp_data_o <= DATA_W'(sig_rdata);
            OP_PRELOAD: begin
              if (lock_q) rsp_err_o <= 1'b1;
              else begin
                preload_stb_o <= 1'b1;
                preload_val_o <= wdata_q;
              end
            end
            OP_ERASE: begin
              st_q       <= ST_SWEEP;
              rsp_done_o <= 1'b0;
              sweep_q    <= '0;
            end
            OP_RSVD: rsp_err_o <= 1'b1;
            default: ;
          endcase
        end
        ST_SWEEP: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_q == LAST_ADDR) begin
            st_q       <= ST_IDLE;
            rsp_done_o <= 1'b1;
            rsp_err_o  <= 1'b0;
            rsp_data_o <= '0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rsp_done_o |=> !rsp_done_o);

  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  // R5
  refused_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rsp_done_o && rsp_err_o) |-> (rsp_data_o == '0));

  // R6
  preload_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    preload_stb_o |-> !lock_q);

  // R9
  unlock_by_erase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(lock_q) && !$past(rst_i)) |-> ($past(st_q) == ST_SWEEP));

  // R6
  preload_with_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    preload_stb_o |-> rsp_done_o);
endmodule

// File: tb/cfg_guard_ctrl_tb_top.sv
module cfg_guard_ctrl_tb_top;
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NV    = 22;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vld = 1'b0;
  logic [2:0]    op  = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd  = '0;
  logic          rdy, done, err, stb, lkd;
  logic [DW-1:0] rdata, pval;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cfg_guard_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_i(rst), .cmd_valid_i(vld), .cmd_op_i(op),
    .cmd_addr_i(addr), .cmd_wdata_i(wd), .cmd_ready_o(rdy),
    .rsp_done_o(done), .rsp_err_o(err), .rsp_data_o(rdata),
    .preload_stb_o(stb), .preload_val_o(pval), .locked_o(lkd)
  );

  // {op, addr, wdata, expected err, expected data}
  localparam logic [25:0] VEC [NV] = '{
    {3'd6, 6'd0,  8'h00, 1'b0, 8'h00},  // R9 erase
    {3'd0, 6'd10, 8'h00, 1'b0, 8'hFF},  // R9 erased word reads all ones
    {3'd1, 6'd5,  8'hA5, 1'b0, 8'h00},  // R3
    {3'd0, 6'd5,  8'h00, 1'b0, 8'hA5},  // R3
    {3'd1, 6'd63, 8'h3C, 1'b0, 8'h00},  // R3
    {3'd0, 6'd63, 8'h00, 1'b0, 8'h3C},  // R3
    {3'd3, 6'd7,  8'h5A, 1'b0, 8'h00},  // R4
    {3'd3, 6'd0,  8'h11, 1'b0, 8'h00},  // R4
    {3'd2, 6'd7,  8'h00, 1'b0, 8'h5A},  // R4
    {3'd2, 6'd0,  8'h00, 1'b0, 8'h11},  // R4
    {3'd4, 6'd0,  8'h96, 1'b0, 8'h00},  // R6 unlocked
    {3'd7, 6'd5,  8'hEE, 1'b1, 8'h00},  // R10 reserved
    {3'd0, 6'd5,  8'h00, 1'b0, 8'hA5},  // R10 nothing changed
    {3'd5, 6'd0,  8'h00, 1'b0, 8'h00},  // R5 lock
    {3'd0, 6'd5,  8'h00, 1'b1, 8'h00},  // R5 R8 refused at once
    {3'd2, 6'd7,  8'h00, 1'b0, 8'h5A},  // R7
    {3'd3, 6'd3,  8'h77, 1'b0, 8'h00},  // R7
    {3'd2, 6'd3,  8'h00, 1'b0, 8'h77},  // R7
    {3'd4, 6'd0,  8'h96, 1'b1, 8'h00},  // R6 locked
    {3'd6, 6'd0,  8'h00, 1'b0, 8'h00},  // R9
    {3'd0, 6'd5,  8'h00, 1'b0, 8'hFF},  // R9 reopened
    {3'd2, 6'd7,  8'h00, 1'b0, 8'h5A}   // R9 signature kept
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic          g_err, g_stb, g_rdy_after;
  logic [DW-1:0] g_data, g_pval;
  int            g_wait;

  task automatic run_cmd(input logic [2:0] o, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!rdy) @(negedge clk);
    vld = 1'b1; op = o; addr = a; wd = d;
    @(negedge clk);
    vld = 1'b0;
    g_rdy_after = rdy;
    g_wait = 1;
    while (!done && g_wait < DEPTH + 20) begin
      @(negedge clk);
      g_wait++;
    end
    g_err = err; g_data = rdata; g_stb = stb; g_pval = pval;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rdy == 1'b1, "R1 ready after reset", rdy, 1);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(lkd == 1'b0, "R1 lock after reset", lkd, 0);
    check(stb == 1'b0, "R1 strobe after reset", stb, 0);

    for (int i = 0; i < NV; i++) begin
      run_cmd(VEC[i][25:23], VEC[i][22:17], VEC[i][16:9]);
      check(g_err == VEC[i][8], $sformatf("vector %0d err", i), g_err, VEC[i][8]);
      check(g_data == VEC[i][7:0], $sformatf("vector %0d data", i), g_data, VEC[i][7:0]);
    end

    // R2 handshake shape
    run_cmd(3'd2, 6'd0, 8'h00);
    check(g_rdy_after == 1'b0, "R2 ready low after accept", g_rdy_after, 0);
    check(g_wait == 2, "R2 done latency", g_wait, 2);
    @(negedge clk);
    check(done == 1'b0, "R2 done is one cycle", done, 0);

    // R6 preload strobe when unlocked
    run_cmd(3'd4, 6'd0, 8'hC3);
    check(g_stb == 1'b1, "R6 strobe unlocked", g_stb, 1);
    check(g_pval == 8'hC3, "R6 preload value", g_pval, 8'hC3);

    // R5 R8 lock, then preload right away
    run_cmd(3'd5, 6'd0, 8'h00);
    check(lkd == 1'b1, "R5 locked flag", lkd, 1);
    run_cmd(3'd4, 6'd0, 8'h3E);
    check(g_stb == 1'b0, "R6 R8 strobe blocked", g_stb, 0);
    check(g_err == 1'b1, "R6 refused flag", g_err, 1);

    // R9 erase duration and unlock
    run_cmd(3'd6, 6'd0, 8'h00);
    check(g_wait >= DEPTH && g_wait <= DEPTH + 3, "R9 erase duration", g_wait, DEPTH + 2);
    check(lkd == 1'b0, "R9 unlocked after erase", lkd, 0);

    // R1 reset clears lock
    run_cmd(3'd5, 6'd0, 8'h00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(lkd == 1'b0, "R1 lock cleared by reset", lkd, 0);
    check(rdy == 1'b1, "R1 ready after second reset", rdy, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule